// File: doc/BRIEF.md
# Base Address Region Map Validator

This block looks at the contents of six base address registers and one expansion-ROM register of a configuration header. It also takes the size and space type of each region and the two enables of the command register. For every region it decides whether the region is currently mapped, and if so at which aligned base address. A downstream transaction decoder uses these per-region valid/base pairs to claim accesses. The decoder is told through a one-cycle change pulse when a region's mapping moves, appears or disappears.

A region counts as unmapped in any of these cases: its space is disabled, its size is zero or not a power of two, its aligned base is zero, its range wraps, an I/O range reaches past the 64 KiB port space, or a memory range ends on the all-ones address. The expansion ROM is always a memory region and needs its own enable bit as well. The block also presents, for each region, the mask of register bits that configuration writes may change, derived from the region size.

Top module: `barMapValidator`

## Requirements
- R1: While `rstN` is low, and at the first cycle after it rises with all inputs zero, every `mapValid`, `mapBase` and `mapChanged` bit is 0.
- R2: `wrMask[n]` equals NOT(`regSize[n]` - 1) for regions 0..5, and the same value with bit 0 forced to 1 for the ROM region (index 6). It follows the size input combinationally, so a size of zero gives a mask of 0 for regions 0..5.
- R3: One clock after the inputs are presented, a mapped region shows `mapBase` = `regVal` AND NOT(`regSize` - 1), so register bits below the size are ignored. An unmapped region shows `mapValid` = 0 and `mapBase` = 0.
- R4: A region with `barIsIo[n]` = 1 is mapped only when `cmdIoEn` = 1, its base is nonzero, its end (base + size - 1) is greater than its base, and its end is below 0x10000.
- R5: A region with `barIsIo[n]` = 0 is mapped only when `cmdMemEn` = 1, its base is nonzero, its end is greater than its base, and its end is not 0xFFFFFFFF.
- R6: The ROM region (index 6) is treated as memory regardless of type. It is mapped only when bit 0 of its register is 1, in addition to the memory rules of R5.
- R7: A region whose size is zero or not a power of two is never mapped.
- R8: `mapChanged[n]` is high for exactly the cycle in which the registered {`mapValid[n]`, `mapBase[n]`} differs from its value one cycle earlier. It stays low when the register changes without changing that pair.
- R9: `cmdIoEn` has no effect on memory regions and `cmdMemEn` has no effect on I/O regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdIoEn | input | 1 | Command register I/O space enable |
| cmdMemEn | input | 1 | Command register memory space enable |
| regVal | input | 7x32 | Current register contents, index 6 is the ROM region |
| regSize | input | 7x32 | Static region sizes in bytes (power of two, 0 = absent) |
| barIsIo | input | 6 | Region 0..5 decodes in I/O space when set |
| wrMask | output | 7x32 | Per-region mask of bits writable by configuration writes |
| mapValid | output | 7 | Region currently mapped |
| mapBase | output | 7x32 | Aligned base of a mapped region, 0 when unmapped |
| mapChanged | output | 7 | One-cycle pulse when a region's valid/base pair changed |

## Verification
A corrupt stored valid/base pair reaches the ports directly. It shows on `mapValid`/`mapBase` one clock after the inputs that should have produced it. It also shows as a missing or spurious `mapChanged` pulse in that same cycle. A stale stored pair that the comparison never refreshes shows up as the outputs staying at an old value after an input change, so each scenario samples one edge after every stimulus. A second sample after that catches pulses that last longer than a cycle. Hidden register changes made while a region is disabled are checked to produce no pulse at all.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int ADDR_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  // decided mapping of one region
  typedef struct packed {
    logic  valid;
    addr_t base;
  } map_t;

  // control -> datapath strobes for one region
  typedef struct packed {
    logic load;
    logic pulse;
  } strobe_t;
endpackage

// File: rtl/barDecodeDp.sv
module barDecodeDp
  import bar_pkg::*;
#(
  parameter int NUM_BARS   = 6,
  parameter int IO_SPACE_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdIoEn,
  input  logic                     cmdMemEn,
  input  addr_t   [NUM_BARS:0]     regVal,
  input  addr_t   [NUM_BARS:0]     regSize,
  input  logic    [NUM_BARS-1:0]   barIsIo,
  input  strobe_t [NUM_BARS:0]     strobes,
  output map_t    [NUM_BARS:0]     candMap,
  output map_t    [NUM_BARS:0]     storedMap,
  output addr_t   [NUM_BARS:0]     wrMask,
  output logic    [NUM_BARS:0]     changedQ
);
  localparam int NUM_REGIONS = NUM_BARS + 1;
  localparam int ROM_IDX     = NUM_BARS;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    addr_t sizeMinus1;
    addr_t alignMask;
    addr_t baseAddr;
    addr_t endAddr;
    logic  sizeOk;
    logic  rangeOk;
    logic  hit;

    always_comb begin
      sizeMinus1 = regSize[g] - addr_t'(1);
      alignMask  = ~sizeMinus1;
      sizeOk     = (regSize[g] != '0) && ((regSize[g] & sizeMinus1) == '0);
      baseAddr   = regVal[g] & alignMask;
      endAddr    = baseAddr + sizeMinus1;
      rangeOk    = sizeOk && (baseAddr != '0) && (endAddr > baseAddr);
    end

    if (g == ROM_IDX) begin : gRom
      // ROM: memory space plus its own enable in bit 0
      assign hit       = cmdMemEn && regVal[g][0] && rangeOk && (endAddr != '1);
      assign wrMask[g] = alignMask | addr_t'(1);
    end else begin : gBar
      logic ioHit;
      logic memHit;
      assign ioHit     = barIsIo[g] && cmdIoEn && rangeOk &&
                         (endAddr[ADDR_W-1:IO_SPACE_W] == '0);
      assign memHit    = !barIsIo[g] && cmdMemEn && rangeOk && (endAddr != '1);
      assign hit       = ioHit || memHit;
      assign wrMask[g] = alignMask;
    end

    assign candMap[g] = hit ? map_t'{valid: 1'b1, base: baseAddr} : map_t'('0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        storedMap[g] <= '0;
        changedQ[g]  <= 1'b0;
      end else begin
        if (strobes[g].load) storedMap[g] <= candMap[g];
        changedQ[g] <= strobes[g].pulse;
      end
    end
  end
endmodule

// File: rtl/barUpdateCtl.sv
module barUpdateCtl
  import bar_pkg::*;
#(
  parameter int NUM_BARS = 6
) (
  input  map_t    [NUM_BARS:0] candMap,
  input  map_t    [NUM_BARS:0] storedMap,
  output strobe_t [NUM_BARS:0] strobes
);
  localparam int NUM_REGIONS = NUM_BARS + 1;

  always_comb begin
    for (int i = 0; i < NUM_REGIONS; i++) begin
      strobes[i].load  = (candMap[i] != storedMap[i]);
      strobes[i].pulse = (candMap[i].valid != storedMap[i].valid) ||
                         (candMap[i].base  != storedMap[i].base);
    end
  end
endmodule

// File: rtl/barMapValidator.sv
module barMapValidator
  import bar_pkg::*;
#(
  parameter int NUM_BARS   = 6,
  parameter int IO_SPACE_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdIoEn,
  input  logic                   cmdMemEn,
  input  addr_t [NUM_BARS:0]     regVal,
  input  addr_t [NUM_BARS:0]     regSize,
  input  logic  [NUM_BARS-1:0]   barIsIo,
  output addr_t [NUM_BARS:0]     wrMask,
  output logic  [NUM_BARS:0]     mapValid,
  output addr_t [NUM_BARS:0]     mapBase,
  output logic  [NUM_BARS:0]     mapChanged
);
  localparam int NUM_REGIONS = NUM_BARS + 1;

  map_t    [NUM_BARS:0] candMap;
  map_t    [NUM_BARS:0] storedMap;
  strobe_t [NUM_BARS:0] strobes;

  barDecodeDp #(.NUM_BARS(NUM_BARS), .IO_SPACE_W(IO_SPACE_W)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmdIoEn  (cmdIoEn),
    .cmdMemEn (cmdMemEn),
    .regVal   (regVal),
    .regSize  (regSize),
    .barIsIo  (barIsIo),
    .strobes  (strobes),
    .candMap  (candMap),
    .storedMap(storedMap),
    .wrMask   (wrMask),
    .changedQ (mapChanged)
  );

  barUpdateCtl #(.NUM_BARS(NUM_BARS)) ctl (
    .candMap  (candMap),
    .storedMap(storedMap),
    .strobes  (strobes)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gOut
    assign mapValid[g] = storedMap[g].valid;
    assign mapBase[g]  = storedMap[g].base;
  end
endmodule

// File: rtl/barMapValidatorChk.sv
module barMapValidatorChk
  import bar_pkg::*;
#(
  parameter int NUM_BARS   = 6,
  parameter int IO_SPACE_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdIoEn,
  input logic                 cmdMemEn,
  input addr_t [NUM_BARS:0]   regVal,
  input addr_t [NUM_BARS:0]   regSize,
  input logic  [NUM_BARS-1:0] barIsIo,
  input logic  [NUM_BARS:0]   mapValid,
  input addr_t [NUM_BARS:0]   mapBase,
  input logic  [NUM_BARS:0]   mapChanged
);
  localparam int NUM_REGIONS = NUM_BARS + 1;
  localparam int ROM_IDX     = NUM_BARS;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gChk
    // R8: pulse exactly when the visible pair moved
    a_r8_pulse_on_move: assert property (@(posedge clk) disable iff (!rstN)
      ({mapValid[g], mapBase[g]} != $past({mapValid[g], mapBase[g]})) |-> mapChanged[g]);
    a_r8_quiet_when_same: assert property (@(posedge clk) disable iff (!rstN)
      ({mapValid[g], mapBase[g]} == $past({mapValid[g], mapBase[g]})) |-> !mapChanged[g]);
    // R3: unmapped base reads zero, mapped base is aligned and nonzero
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
      !mapValid[g] |-> (mapBase[g] == '0));
    a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rstN)
      mapValid[g] |-> (((mapBase[g] & ($past(regSize[g]) - addr_t'(1))) == '0) &&
                       (mapBase[g] != '0)));
    // R7: no mapping without a size
    a_r7_size_nonzero: assert property (@(posedge clk) disable iff (!rstN)
      mapValid[g] |-> ($past(regSize[g]) != '0));

    if (g == ROM_IDX) begin : gRomChk
      // R6: ROM needs its own enable and the memory enable
      a_r6_rom_enable: assert property (@(posedge clk) disable iff (!rstN)
        mapValid[g] |-> ($past(regVal[g][0]) && $past(cmdMemEn)));
    end else begin : gBarChk
      // R4: mapped I/O region stays inside the port space and needs the I/O enable
      a_r4_io_bound: assert property (@(posedge clk) disable iff (!rstN)
        (mapValid[g] && $past(barIsIo[g])) |->
          ($past(cmdIoEn) &&
           (((mapBase[g] + $past(regSize[g]) - addr_t'(1)) >> IO_SPACE_W) == '0)));
      // R5: mapped memory region needs the memory enable
      a_r5_mem_enable: assert property (@(posedge clk) disable iff (!rstN)
        (mapValid[g] && !$past(barIsIo[g])) |-> $past(cmdMemEn));
    end
  end
endmodule

bind barMapValidator barMapValidatorChk #(.NUM_BARS(NUM_BARS), .IO_SPACE_W(IO_SPACE_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdIoEn   (cmdIoEn),
  .cmdMemEn  (cmdMemEn),
  .regVal    (regVal),
  .regSize   (regSize),
  .barIsIo   (barIsIo),
  .mapValid  (mapValid),
  .mapBase   (mapBase),
  .mapChanged(mapChanged)
);

// File: tb/barMapValidator_test.sv
`timescale 1ns/1ps
module barMapValidator_test;
  import bar_pkg::*;

  localparam int NB = 6;
  localparam int NR = NB + 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdIoEn = 1'b0;
  logic            cmdMemEn = 1'b0;
  addr_t [NB:0]    regVal = '0;
  addr_t [NB:0]    regSize = '0;
  logic  [NB-1:0]  barIsIo = '0;
  addr_t [NB:0]    wrMask;
  logic  [NB:0]    mapValid;
  addr_t [NB:0]    mapBase;
  logic  [NB:0]    mapChanged;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  barMapValidator #(.NUM_BARS(NB), .IO_SPACE_W(16)) uut (
    .clk(clk), .rstN(rstN), .cmdIoEn(cmdIoEn), .cmdMemEn(cmdMemEn),
    .regVal(regVal), .regSize(regSize), .barIsIo(barIsIo),
    .wrMask(wrMask), .mapValid(mapValid), .mapBase(mapBase), .mapChanged(mapChanged)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkMap(int idx, logic expV, addr_t expB, logic expC, string req);
    checks++;
    if (mapValid[idx] !== expV || mapBase[idx] !== expB || mapChanged[idx] !== expC) begin
      fails++;
      $display("FAIL %s region %0d: valid/base/changed got %0b/%h/%0b expected %0b/%h/%0b",
               req, idx, mapValid[idx], mapBase[idx], mapChanged[idx], expV, expB, expC);
    end
  endtask

  task automatic checkMask(int idx, addr_t exp, string req);
    checks++;
    if (wrMask[idx] !== exp) begin
      fails++;
      $display("FAIL %s region %0d: wrMask got %h expected %h", req, idx, wrMask[idx], exp);
    end
  endtask

  task automatic clearRegion(int idx);
    @(negedge clk);
    regSize[idx] = '0;
    regVal[idx]  = '0;
    tick();
    tick();
  endtask

  task automatic testReset();
    for (int i = 0; i < NR; i++) checkMap(i, 1'b0, '0, 1'b0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    tick();
    for (int i = 0; i < NR; i++) checkMap(i, 1'b0, '0, 1'b0, "R1");
  endtask

  task automatic testWrMask();
    @(negedge clk);
    regSize[4] = 32'h100;
    regSize[5] = 32'h4;
    regSize[6] = 32'h800;
    #1;
    checkMask(4, 32'hFFFF_FF00, "R2");
    checkMask(5, 32'hFFFF_FFFC, "R2");
    checkMask(6, 32'hFFFF_F801, "R2");
    regSize[4] = '0;
    #1;
    checkMask(4, 32'h0, "R2");
    regSize[5] = '0;
    regSize[6] = '0;
  endtask

  task automatic testMemMap();
    @(negedge clk);
    cmdMemEn = 1'b1;
    barIsIo[0] = 1'b0;
    regSize[0] = 32'h1000;
    regVal[0]  = 32'h8000_0ABC;
    tick();
    checkMap(0, 1'b1, 32'h8000_0000, 1'b1, "R3/R5/R8 map");
    tick();
    checkMap(0, 1'b1, 32'h8000_0000, 1'b0, "R8 single pulse");
    @(negedge clk);
    regVal[0] = 32'h8000_0FFF;
    tick();
    checkMap(0, 1'b1, 32'h8000_0000, 1'b0, "R3 low bits ignored");
    @(negedge clk);
    regVal[0] = 32'h9000_0000;
    tick();
    checkMap(0, 1'b1, 32'h9000_0000, 1'b1, "R8 base move");
    @(negedge clk);
    regSize[0] = '0;
    tick();
    checkMap(0, 1'b0, '0, 1'b1, "R7/R8 unmap");
    clearRegion(0);
  endtask

  task automatic testMemIllegal();
    @(negedge clk);
    cmdMemEn = 1'b1;
    regSize[2] = 32'h1000;
    regVal[2]  = 32'h0000_0FFF;
    tick();
    checkMap(2, 1'b0, '0, 1'b0, "R5 zero base");
    @(negedge clk);
    regVal[2] = 32'hFFFF_F000;
    tick();
    checkMap(2, 1'b0, '0, 1'b0, "R5 end all ones");
    @(negedge clk);
    regVal[2] = 32'hFFFF_E000;
    tick();
    checkMap(2, 1'b1, 32'hFFFF_E000, 1'b1, "R5 top legal");
    @(negedge clk);
    cmdMemEn = 1'b0;
    tick();
    checkMap(2, 1'b0, '0, 1'b1, "R5 disabled");
    clearRegion(2);
    cmdMemEn = 1'b1;
  endtask

  task automatic testIo();
    @(negedge clk);
    cmdIoEn = 1'b1;
    barIsIo[1] = 1'b1;
    regSize[1] = 32'h20;
    regVal[1]  = 32'h0000_C001;
    tick();
    checkMap(1, 1'b1, 32'h0000_C000, 1'b1, "R4 io map");
    @(negedge clk);
    regVal[1] = 32'h0000_FFE0;
    tick();
    checkMap(1, 1'b1, 32'h0000_FFE0, 1'b1, "R4 io last window");
    @(negedge clk);
    regVal[1] = 32'h0001_0000;
    tick();
    checkMap(1, 1'b0, '0, 1'b1, "R4 io beyond 64K");
    @(negedge clk);
    regVal[1] = 32'h0000_C000;
    cmdIoEn = 1'b0;
    tick();
    checkMap(1, 1'b0, '0, 1'b0, "R4 io disabled");
    clearRegion(1);
  endtask

  task automatic testRom();
    @(negedge clk);
    cmdMemEn = 1'b1;
    regSize[6] = 32'h1_0000;
    regVal[6]  = 32'hE000_0001;
    tick();
    checkMap(6, 1'b1, 32'hE000_0000, 1'b1, "R6 rom on");
    checkMask(6, 32'hFFFF_0001, "R2 rom mask");
    @(negedge clk);
    regVal[6] = 32'hE000_0000;
    tick();
    checkMap(6, 1'b0, '0, 1'b1, "R6 rom enable clear");
    @(negedge clk);
    regVal[6] = 32'hE000_0001;
    cmdMemEn = 1'b0;
    tick();
    checkMap(6, 1'b0, '0, 1'b0, "R6 rom needs memory enable");
    clearRegion(6);
    cmdMemEn = 1'b1;
  endtask

  task automatic testSize();
    @(negedge clk);
    cmdMemEn = 1'b1;
    barIsIo[3] = 1'b0;
    regSize[3] = '0;
    regVal[3]  = 32'h4000_0000;
    tick();
    checkMap(3, 1'b0, '0, 1'b0, "R7 size zero");
    @(negedge clk);
    regSize[3] = 32'h30;
    tick();
    checkMap(3, 1'b0, '0, 1'b0, "R7 size not power of two");
    @(negedge clk);
    regSize[3] = 32'h40;
    tick();
    checkMap(3, 1'b1, 32'h4000_0000, 1'b1, "R7 legal size");
    clearRegion(3);
  endtask

  task automatic testHiddenChange();
    @(negedge clk);
    cmdMemEn = 1'b0;
    barIsIo[5] = 1'b0;
    regSize[5] = 32'h100;
    regVal[5]  = 32'h0000_1000;
    tick();
    checkMap(5, 1'b0, '0, 1'b0, "R8 disabled no pulse");
    @(negedge clk);
    regVal[5] = 32'h0000_2000;
    tick();
    checkMap(5, 1'b0, '0, 1'b0, "R8 hidden change no pulse");
    @(negedge clk);
    cmdMemEn = 1'b1;
    tick();
    checkMap(5, 1'b1, 32'h0000_2000, 1'b1, "R8 enable pulse");
    clearRegion(5);
  endtask

  task automatic testCross();
    @(negedge clk);
    cmdIoEn = 1'b0;
    cmdMemEn = 1'b1;
    barIsIo[1] = 1'b1;
    regSize[1] = 32'h20;
    regVal[1]  = 32'h0000_C000;
    tick();
    checkMap(1, 1'b0, '0, 1'b0, "R9 io ignores memory enable");
    clearRegion(1);
    @(negedge clk);
    cmdIoEn = 1'b1;
    cmdMemEn = 1'b0;
    barIsIo[0] = 1'b0;
    regSize[0] = 32'h1000;
    regVal[0]  = 32'h8000_0000;
    tick();
    checkMap(0, 1'b0, '0, 1'b0, "R9 memory ignores io enable");
    clearRegion(0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    tick();
    tick();
    tick();
    testReset();
    testWrMask();
    testMemMap();
    testMemIllegal();
    testIo();
    testRom();
    testSize();
    testHiddenChange();
    testCross();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL all: watchdog expired got running expected finished");
      summary();
      $finish;
    end
  end
endmodule